// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Trigger Mode

This block keeps the pending-request bits for one interrupt controller, one bit per request line. Each line is either edge triggered or level triggered, as chosen by a trigger-mode register. The register is written through its own write port. Bits that the instance does not allow to be written always read as zero.

An edge-triggered line latches a request when its input rises. The request then stays pending until something takes it away. That can be an acknowledge, a bulk-clear operation or a reset. A level-triggered line simply mirrors its input, delayed by one clock. An acknowledge removes an edge-triggered request only. Two bulk masks let the surrounding controller force pending bits on or off in a single cycle.

Priority resolution, masking and vector generation belong to neighbouring logic. They read the pending vector that this block drives.

Top module: `irq_request_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) shows pending equal to its input as sampled at the previous rising clock edge. Line i corresponds to bit i of every vector.
- R2: A line whose trigger-mode bit is 0 (edge) becomes pending one clock after a sample where its input is 1 and the previous clock's sample was 0.
- R3: An edge-triggered pending bit is not cleared when the input goes low. An input held high does not set it again once it has been removed.
- R4: The remembered previous sample is updated every clock in both modes. A line switched from level to edge while its input stays high sees no rising edge.
- R5: An acknowledge (strobe high, binary line number on the 3-bit select) clears that line's pending bit on the next clock only if the line is edge triggered. A level-triggered line is unaffected.
- R6: If an acknowledge and a rising edge hit the same edge-triggered line in the same cycle, the line stays pending.
- R7: A trigger-mode write stores the write data ANDed with the instance parameter WRITE_MASK (default 0xF8), visible one clock later. Bits outside the mask read 0, and the value holds when no write occurs.
- R8: The bulk-set mask ORs into the pending bits and the bulk-clear mask then removes bits. These masks act on top of that cycle's sampling and acknowledge, and clear wins when both name a line.
- R9: A synchronous reset clears the pending bits, the remembered samples and the trigger-mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 8 | Raw request levels, one per line |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Binary number of the acknowledged line |
| bulk_set | input | 8 | Pending bits to force on |
| bulk_clr | input | 8 | Pending bits to force off |
| mode_we | input | 1 | Trigger-mode register write enable |
| mode_wdata | input | 8 | Trigger-mode write data, 1 = level, 0 = edge |
| pending | output | 8 | Pending-request vector |
| trig_mode | output | 8 | Trigger-mode register value |

## Verification
The bench acknowledges a level-triggered line and expects the bit to stay set. A design that cleared it would drop a request whose input is still asserted. It then switches a line from level to edge while the input stays high and acknowledges it. A design that tracked the previous sample only in edge mode would see a false edge and set the bit again. The bench also lands an acknowledge on the same cycle as a new rising edge, where a design that gave acknowledge priority would lose the interrupt. It applies bulk set and clear to the same line, and writes all-ones to the mode register, where a missing mask would expose the low bits. A long random phase with mode changes and resets is compared against a behavioural model on every clock.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Registered state of one request line.
    typedef struct packed {
        logic pend;   // request pending
        logic last;   // input sample from the previous clock
    } line_state_t;

endpackage

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
    parameter int NLINES = 8,
    localparam int SELW = $clog2(NLINES)
) (
    input  logic              ack_valid,
    input  logic [SELW-1:0]   ack_line,
    output logic [NLINES-1:0] ack_hit
);

    always_comb begin
        ack_hit = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (ack_valid && (ack_line == SELW'(i))) begin
                ack_hit[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
    parameter int                NLINES     = 8,
    parameter logic [NLINES-1:0] WRITE_MASK = 8'hF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] mode
);

    logic [NLINES-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d = wdata & WRITE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    // R7: a write lands masked one clock later
    a_r7_masked_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (mode == ($past(wdata) & WRITE_MASK)));

    // R7: no write, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mode));

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic level_mode,
    input  logic ack_hit,
    input  logic force_set,
    input  logic force_clr,
    output logic pend
);

    line_state_t st_d, st_q;
    logic        rise;

    assign rise = raw && !st_q.last;

    always_comb begin
        st_d = st_q;
        if (level_mode) begin
            st_d.pend = raw;
        end else begin
            if (ack_hit) begin
                st_d.pend = 1'b0;
            end
            if (rise) begin
                st_d.pend = 1'b1;   // new edge beats acknowledge
            end
        end
        if (force_set) begin
            st_d.pend = 1'b1;
        end
        if (force_clr) begin
            st_d.pend = 1'b0;
        end
        st_d.last = raw;            // tracked in both modes
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    // R1 / R5: level line mirrors the input, acknowledge ignored
    a_r1_level_follow: assert property (@(posedge clk) disable iff (rst)
        (level_mode && !force_set && !force_clr) |=> (pend == $past(raw)));

    // R2 / R6: a rising edge on an edge line always sets the bit
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && raw && !st_q.last && !force_clr) |=> pend);

    // R3: without an event an edge line holds its bit
    a_r3_edge_hold: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && !ack_hit && !rise && !force_set && !force_clr)
        |=> $stable(pend));

    // R5: acknowledge removes an edge request
    a_r5_edge_ack: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && ack_hit && !rise && !force_set) |=> !pend);

    // R8: bulk clear wins
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
        force_clr |=> !pend);

endmodule

// File: rtl/irq_request_latch.sv
module irq_request_latch #(
    parameter int                NLINES     = 8,
    parameter logic [NLINES-1:0] WRITE_MASK = 8'hF8,
    localparam int               SELW       = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] req_in,
    input  logic              ack_valid,
    input  logic [SELW-1:0]   ack_line,
    input  logic [NLINES-1:0] bulk_set,
    input  logic [NLINES-1:0] bulk_clr,
    input  logic              mode_we,
    input  logic [NLINES-1:0] mode_wdata,
    output logic [NLINES-1:0] pending,
    output logic [NLINES-1:0] trig_mode
);

    logic [NLINES-1:0] ack_hit;

    irq_ack_decode #(.NLINES(NLINES)) u_dec (
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .ack_hit   (ack_hit)
    );

    irq_trig_reg #(.NLINES(NLINES), .WRITE_MASK(WRITE_MASK)) u_mode (
        .clk   (clk),
        .rst   (rst),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (trig_mode)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        irq_line_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .raw        (req_in[i]),
            .level_mode (trig_mode[i]),
            .ack_hit    (ack_hit[i]),
            .force_set  (bulk_set[i]),
            .force_clr  (bulk_clr[i]),
            .pend       (pending[i])
        );
    end

    // R9: reset empties pending bits and trigger modes
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> ((pending == '0) && (trig_mode == '0)));

endmodule

// File: tb/sim_irq_request_latch.sv
`timescale 1ns/1ps
module sim_irq_request_latch;

    localparam logic [7:0] MASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_line = '0;
    logic [7:0] bulk_set = '0;
    logic [7:0] bulk_clr = '0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] pending;
    logic [7:0] trig_mode;

    int checks = 0;
    int errors = 0;
    string cur_req = "R9";

    irq_request_latch u0 (
        .clk(clk), .rst(rst), .req_in(req_in), .ack_valid(ack_valid),
        .ack_line(ack_line), .bulk_set(bulk_set), .bulk_clr(bulk_clr),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .pending(pending), .trig_mode(trig_mode)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference, updated at each rising edge
    bit [7:0] m_pend = '0, m_last = '0, m_mode = '0;
    always @(posedge clk) begin
        if (rst) begin
            m_pend = '0; m_last = '0; m_mode = '0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (m_mode[i]) begin
                    m_pend[i] = req_in[i];
                end else begin
                    if (ack_valid && ack_line == i) m_pend[i] = 1'b0;
                    if (req_in[i] && !m_last[i]) m_pend[i] = 1'b1;
                end
            end
            m_pend = (m_pend | bulk_set) & ~bulk_clr;
            m_last = req_in;
            if (mode_we) m_mode = mode_wdata & MASK;
        end
    end

    // Model compare every clock, away from the edge
    always @(negedge clk) begin
        checks++;
        if (pending !== m_pend || trig_mode !== m_mode) begin
            errors++;
            $display("FAIL %s model: pending=%h trig=%h expected pending=%h trig=%h",
                     cur_req, pending, trig_mode, m_pend, m_mode);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0; bulk_set = '0; bulk_clr = '0; mode_we = 1'b0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wmode(input logic [7:0] v);
        mode_we = 1'b1; mode_wdata = v;
    endtask

    task automatic ack(input int n);
        ack_valid = 1'b1; ack_line = 3'(n);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        chk("R9", pending, 8'h00);
        chk("R9", trig_mode, 8'h00);
        rst = 1'b0;

        cur_req = "R7";
        wmode(8'hFF); step();
        chk("R7", trig_mode, 8'hF8);
        wmode(8'h07); step();
        chk("R7", trig_mode, 8'h00);
        wmode(8'hF0); step();
        step();
        chk("R7", trig_mode, 8'hF0);

        cur_req = "R1";
        req_in = 8'h10; step();
        chk("R1", pending, 8'h10);
        req_in = 8'h00; step();
        chk("R1", pending, 8'h00);

        cur_req = "R2";
        req_in = 8'h01; step();
        chk("R2", pending, 8'h01);

        cur_req = "R3";
        req_in = 8'h00; step();
        chk("R3", pending, 8'h01);
        ack(0); step();
        chk("R3", pending, 8'h00);
        req_in = 8'h01; step();
        ack(0); step();
        step();
        chk("R3", pending, 8'h00);

        cur_req = "R5";
        req_in = 8'h20; step();
        ack(5); step();
        chk("R5", pending, 8'h20);
        req_in = 8'h00; step();

        cur_req = "R6";
        req_in = 8'h02; ack(1); step();
        chk("R6", pending, 8'h02);
        req_in = 8'h00; ack(1); step();
        chk("R6", pending, 8'h00);

        cur_req = "R4";
        wmode(8'hF8); step();
        req_in = 8'h08; step();
        wmode(8'hF0); step();
        ack(3); step();
        chk("R4", pending, 8'h00);
        step();
        chk("R4", pending, 8'h00);
        req_in = 8'h00; step();

        cur_req = "R8";
        bulk_set = 8'h0C; step();
        chk("R8", pending, 8'h0C);
        bulk_clr = 8'h04; step();
        chk("R8", pending, 8'h08);
        bulk_set = 8'h01; bulk_clr = 8'h09; step();
        chk("R8", pending, 8'h00);

        cur_req = "R9";
        bulk_set = 8'hFF; wmode(8'hFF); step();
        rst = 1'b1; step();
        rst = 1'b0;
        chk("R9", pending, 8'h00);
        chk("R9", trig_mode, 8'h00);

        cur_req = "random";
        for (int n = 0; n < 4000; n++) begin
            req_in    = 8'($urandom);
            ack_valid = ($urandom % 3) == 0;
            ack_line  = 3'($urandom);
            bulk_set  = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            bulk_clr  = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
            mode_we   = ($urandom % 16) == 0;
            mode_wdata = 8'($urandom);
            rst       = ($urandom % 200) == 0;
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule